// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Decimal Adjust

This block performs the arithmetic of an 8-bit accumulator machine. Each operation takes the accumulator, a second operand, the B register and the CY, AC and OV flags. It returns a new accumulator, a new B value and updated flags.

Addition, addition with carry, subtraction with borrow, packed-BCD decimal adjust, increment and decrement each finish in a single clock. Multiply and divide work on the A:B register pair and run iteratively over `STEPS` clocks, handling `W/STEPS` bits per clock.

The caller presents an operation code and operands with a one-cycle `start` pulse. It then waits for `done`. The results and flags stay on the outputs until the next operation completes. A `start` that arrives while `busy` is high is ignored.

Top module: `acc_arith_unit`

## Requirements
- R1: Operation code 0 (add) and code 1 (add with carry) set `acc_o` to the low 8 bits of A + operand, plus CY for code 1 only. `cy_o` is the carry out of bit 7. `b_o` equals `b_i`.
- R2: Operation code 2 (subtract with borrow) sets `acc_o` to A − operand − CY, modulo 256. `cy_o` is 1 exactly when the true difference is negative.
- R3: For codes 0, 1 and 2, `ac_o` is the carry into bit 4 (for subtraction, the borrow into bit 4). `ov_o` is 1 exactly when the 8-bit two's-complement result overflows.
- R4: Operation code 3 (decimal adjust) first adds 06h when the low nibble of A is above 9 or AC is 1. It then adds 60h when the resulting high nibble is above 9 or when CY, or the carry from the first step, is 1. `cy_o` is set by any carry out and is never cleared. AC and OV pass through unchanged.
- R5: Operation code 4 increments A and code 5 decrements A, both modulo 256. `b_o`, `cy_o`, `ac_o` and `ov_o` equal their inputs.
- R6: Operation code 7… (see R7). Operation code 6 (multiply) places the low byte of A×B in `acc_o` and the high byte in `b_o`. `ov_o` is 1 exactly when the product exceeds FFh, `cy_o` is 0, and AC passes through.
- R7: Operation code 7 (divide) with B nonzero places the quotient of A/B in `acc_o` and the remainder in `b_o`, with `ov_o` = 0 and `cy_o` = 0.
- R8: Divide with B = 0 returns A and B unchanged, with `ov_o` = 1 and `cy_o` = 0.
- R9: A single-cycle operation raises `done` one clock after `start` is sampled, and `busy` stays low.
- R10: Multiply and divide hold `busy` high for exactly `STEPS` clocks after `start`, then raise `done` on the next clock with `busy` low. A `start` seen while `busy` is high is ignored.
- R11: While reset is held, `busy`, `done`, `acc_o`, `b_o` and the flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the operation on `op` |
| op | input | 3 | Operation code (0 add … 7 divide) |
| acc_i | input | W | Accumulator value |
| opnd_i | input | W | Second operand for add and subtract |
| b_i | input | W | B register value |
| cy_i | input | 1 | Carry flag in |
| ac_i | input | 1 | Auxiliary carry flag in |
| ov_i | input | 1 | Overflow flag in |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | Result valid pulse |
| acc_o | output | W | New accumulator |
| b_o | output | W | New B register |
| cy_o | output | 1 | New carry flag |
| ac_o | output | 1 | New auxiliary carry flag |
| ov_o | output | 1 | New overflow flag |

## Verification
On every cycle, the assertions check the handshake timing: the one-clock completion of single-cycle operations, the busy window of iterative operations, and no `done` while `busy`. They also check the flag rules that follow from the outputs alone: after a multiply, OV tracks a nonzero high byte and CY is clear; after a divide, CY is clear; increment and decrement leave B and CY alone.

The arithmetic values can only be shown by the bench's sweeps. These cover the sums and differences with their AC and OV, the BCD adjustment of all 1024 input combinations, products and quotients, the divide-by-zero hold, and a start pulse ignored mid-iteration.

// File: rtl/acc_arith_unit.sv
module acc_arith_unit #(
  parameter int W     = 8,
  parameter int STEPS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  input  logic         ac_i,
  input  logic         ov_i,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] b_o,
  output logic         cy_o,
  output logic         ac_o,
  output logic         ov_o
);
  localparam int R  = W / STEPS;
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [2:0] OP_ADD = 3'd0, OP_ADDC = 3'd1, OP_SUBB = 3'd2, OP_DA = 3'd3,
                         OP_INC = 3'd4, OP_DEC = 3'd5, OP_MUL = 3'd6, OP_DIV = 3'd7;

  logic          use_cy;
  logic [W:0]    sum, dif, da1, da2;
  logic [W-1:0]  sum_x, dif_x;
  logic          da_lo_fix, da_c1, da_hi_fix;

  assign use_cy = (op == OP_ADDC || op == OP_SUBB) && cy_i;
  assign sum = {1'b0, acc_i} + {1'b0, opnd_i} + {{W{1'b0}}, use_cy};
  assign dif = {1'b0, acc_i} - {1'b0, opnd_i} - {{W{1'b0}}, use_cy};
  assign sum_x = acc_i ^ opnd_i ^ sum[W-1:0];
  assign dif_x = acc_i ^ opnd_i ^ dif[W-1:0];

  assign da_lo_fix = (acc_i[3:0] > 4'd9) || ac_i;
  assign da1 = {1'b0, acc_i} + (da_lo_fix ? {{(W-3){1'b0}}, 4'd6} : '0);
  assign da_c1 = cy_i | da1[W];
  assign da_hi_fix = (da1[W-1:4] > (W-4)'(9)) || da_c1;
  assign da2 = {1'b0, da1[W-1:0]} + (da_hi_fix ? {{(W-6){1'b0}}, 7'h60} : '0);

  logic [W-1:0] s_acc;
  logic         s_cy, s_ac, s_ov;

  always_comb begin
    s_acc = acc_i;
    s_cy  = cy_i;
    s_ac  = ac_i;
    s_ov  = ov_i;
    case (op)
      OP_ADD, OP_ADDC: begin
        s_acc = sum[W-1:0];
        s_cy  = sum[W];
        s_ac  = sum_x[4];
        s_ov  = (acc_i[W-1] == opnd_i[W-1]) && (sum[W-1] != acc_i[W-1]);
      end
      OP_SUBB: begin
        s_acc = dif[W-1:0];
        s_cy  = dif[W];
        s_ac  = dif_x[4];
        s_ov  = (acc_i[W-1] != opnd_i[W-1]) && (dif[W-1] != acc_i[W-1]);
      end
      OP_DA: begin
        s_acc = da2[W-1:0];
        s_cy  = da_c1 | da2[W];
      end
      OP_INC: s_acc = acc_i + 1'b1;
      OP_DEC: s_acc = acc_i - 1'b1;
      default: ;
    endcase
  end

  logic [2:0]     op_q;
  logic [W-1:0]   a_q, b_q, wq, wr;
  logic [2*W-1:0] prod;
  logic [CW-1:0]  cnt;
  logic           ac_q;

  logic [W-1:0]   q_n, r_n;
  logic [2*W-1:0] p_n;
  logic [W:0]     t_r;

  always_comb begin
    q_n = wq;
    r_n = wr;
    p_n = prod;
    t_r = '0;
    if (op_q == OP_MUL) begin
      for (int i = 0; i < R; i++)
        if (wq[i]) p_n = p_n + ({{W{1'b0}}, a_q} << (int'(cnt) * R + i));
      q_n = wq >> R;
    end else begin
      for (int i = 0; i < R; i++) begin
        t_r = {r_n, q_n[W-1]};
        q_n = {q_n[W-2:0], 1'b0};
        if (t_r >= {1'b0, b_q}) begin
          t_r    = t_r - {1'b0, b_q};
          q_n[0] = 1'b1;
        end
        r_n = t_r[W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      acc_o <= '0;
      b_o  <= '0;
      cy_o <= 1'b0;
      ac_o <= 1'b0;
      ov_o <= 1'b0;
      op_q <= OP_ADD;
      a_q  <= '0;
      b_q  <= '0;
      wq   <= '0;
      wr   <= '0;
      prod <= '0;
      cnt  <= '0;
      ac_q <= 1'b0;
    end else if (busy) begin
      wq   <= q_n;
      wr   <= r_n;
      prod <= p_n;
      cnt  <= cnt + 1'b1;
      if (cnt == CW'(STEPS - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
        cy_o <= 1'b0;
        ac_o <= ac_q;
        if (op_q == OP_MUL) begin
          acc_o <= p_n[W-1:0];
          b_o   <= p_n[2*W-1:W];
          ov_o  <= |p_n[2*W-1:W];
        end else if (b_q == '0) begin
          acc_o <= a_q;
          b_o   <= b_q;
          ov_o  <= 1'b1;
        end else begin
          acc_o <= q_n;
          b_o   <= r_n;
          ov_o  <= 1'b0;
        end
      end
    end else if (start) begin
      if (op == OP_MUL || op == OP_DIV) begin
        busy <= 1'b1;
        done <= 1'b0;
        op_q <= op;
        a_q  <= acc_i;
        b_q  <= b_i;
        ac_q <= ac_i;
        wq   <= (op == OP_MUL) ? b_i : acc_i;
        wr   <= '0;
        prod <= '0;
        cnt  <= '0;
      end else begin
        done  <= 1'b1;
        acc_o <= s_acc;
        b_o   <= b_i;
        cy_o  <= s_cy;
        ac_o  <= s_ac;
        ov_o  <= s_ov;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_arith_unit_chk.sv
module acc_arith_unit_chk #(
  parameter int W     = 8,
  parameter int STEPS = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [2:0]   op,
  input logic [W-1:0] b_i,
  input logic         cy_i,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] b_o,
  input logic         cy_o,
  input logic         ov_o
);
  logic [2:0]   last_op;
  logic [W-1:0] last_b;
  logic         last_cy;
  int           bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_op <= 3'd0;
      last_b  <= '0;
      last_cy <= 1'b0;
      bcnt    <= 0;
    end else begin
      if (start && !busy) begin
        last_op <= op;
        last_b  <= b_i;
        last_cy <= cy_i;
      end
      bcnt <= busy ? bcnt + 1 : 0;
    end
  end

  // R9
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && op < 3'd6 |=> done && !busy);
  // R10
  iter_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && op >= 3'd6 |=> busy && !done);
  // R10
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < STEPS);
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R10
  no_done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  // R6
  mul_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && last_op == 3'd6 |-> !cy_o && (ov_o == (b_o != '0)));
  // R7
  div_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && last_op == 3'd7 |-> !cy_o);
  // R5
  incdec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (last_op == 3'd4 || last_op == 3'd5) |-> b_o == last_b && cy_o == last_cy);
endmodule

bind acc_arith_unit acc_arith_unit_chk #(.W(W), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .b_i(b_i), .cy_i(cy_i),
  .busy(busy), .done(done), .b_o(b_o), .cy_o(cy_o), .ov_o(ov_o)
);

// File: tb/acc_arith_unit_tb.sv
`timescale 1ns/1ps
module acc_arith_unit_tb;
  localparam int STEPS = 4;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] acc_i = '0, opnd_i = '0, b_i = '0;
  logic cy_i = 1'b0, ac_i = 1'b0, ov_i = 1'b0;
  logic busy, done, cy_o, ac_o, ov_o;
  logic [7:0] acc_o, b_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  acc_arith_unit #(.W(8), .STEPS(STEPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .acc_i(acc_i), .opnd_i(opnd_i),
    .b_i(b_i), .cy_i(cy_i), .ac_i(ac_i), .ov_i(ov_i), .busy(busy), .done(done),
    .acc_o(acc_o), .b_o(b_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o));

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic model(input int o, a, d, b, cy, ac, ov,
                       output int ea, eb, ecy, eac, eov);
    int s, c, t, c1;
    ea = a; eb = b; ecy = cy; eac = ac; eov = ov;
    case (o)
      0, 1: begin
        c = (o == 1) ? cy : 0;
        s = a + d + c;
        ea = s & 255; ecy = (s > 255);
        eac = (((a & 15) + (d & 15) + c) > 15);
        eov = (((a ^ d) & 128) == 0) && (((a ^ s) & 128) != 0);
      end
      2: begin
        s = a - d - cy;
        ea = s & 255; ecy = (s < 0);
        eac = (((a & 15) - (d & 15) - cy) < 0);
        eov = (((a ^ d) & 128) != 0) && (((a ^ ea) & 128) != 0);
      end
      3: begin
        t = a;
        if ((t & 15) > 9 || ac) t = t + 6;
        c1 = cy | (t > 255);
        t = t & 255;
        if ((t >> 4) > 9 || c1) t = t + 96;
        ecy = c1 | (t > 255);
        ea = t & 255;
      end
      4: ea = (a + 1) & 255;
      5: ea = (a + 255) & 255;
      6: begin
        s = a * b;
        ea = s & 255; eb = s >> 8; ecy = 0; eov = (s > 255);
      end
      default: begin
        ecy = 0;
        if (b == 0) eov = 1;
        else begin ea = a / b; eb = a % b; eov = 0; end
      end
    endcase
  endtask

  task automatic run(input int o, a, d, b, cy, ac, ov, input string tag);
    int ea, eb, ecy, eac, eov, n, lat;
    bit busy_ok;
    model(o, a, d, b, cy, ac, ov, ea, eb, ecy, eac, eov);
    @(negedge clk);
    op = o[2:0]; acc_i = a[7:0]; opnd_i = d[7:0]; b_i = b[7:0];
    cy_i = cy[0]; ac_i = ac[0]; ov_i = ov[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    busy_ok = (o >= 6) ? busy : !busy;
    while (!done && n < 20) begin
      if (n == 2) begin
        start = 1'b1; op = 3'd4; acc_i = ~a[7:0]; b_i = ~b[7:0];
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    lat = (o >= 6) ? STEPS + 1 : 1;
    checks++;
    if (!done || n != lat || !busy_ok || busy || acc_o != ea[7:0] || b_o != eb[7:0] ||
        cy_o != ecy[0] || ac_o != eac[0] || ov_o != eov[0]) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h d=%02h b=%02h cy=%0d ac=%0d: got acc=%02h b=%02h cy=%0d ac=%0d ov=%0d lat=%0d busyok=%0d, exp acc=%02h b=%02h cy=%0d ac=%0d ov=%0d lat=%0d",
               tag, o, a, d, b, cy, ac, acc_o, b_o, cy_o, ac_o, ov_o, n, busy_ok,
               ea, eb, ecy, eac, eov, lat);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R11
    if (busy || done || acc_o != 8'h00 || b_o != 8'h00 || cy_o || ac_o || ov_o) begin
      errors++;
      $display("FAIL R11 reset: got busy=%0d done=%0d acc=%02h b=%02h, exp all zero",
               busy, done, acc_o, b_o);
    end
    rst_n = 1'b1;

    // R1 and R3: add and add with carry sweeps
    for (int a = 0; a < 256; a += 5)
      for (int d = 0; d < 256; d += 7)
        for (int c = 0; c < 2; c++) begin
          run(0, a, d, 8'h5a, c, 0, 0, "R1/R3 add");
          run(1, a, d, 8'h5a, c, 1, 1, "R1/R3 addc");
        end
    // R2 and R3: subtract with borrow sweep
    for (int a = 0; a < 256; a += 5)
      for (int d = 0; d < 256; d += 7)
        for (int c = 0; c < 2; c++)
          run(2, a, d, 8'h33, c, 0, 1, "R2/R3 subb");
    // R1: worked example 44h + CAh then 1Eh + 56h + CY
    run(0, 8'h44, 8'hca, 0, 0, 0, 0, "R1 add example");
    run(1, 8'h1e, 8'h56, 0, 1, 0, 0, "R1 addc example");
    // R4: exhaustive decimal adjust
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 4; f++)
        run(3, a, 0, 8'h11, f & 1, f >> 1, f & 1, "R4 decimal adjust");
    run(3, 8'h7d, 0, 0, 0, 0, 0, "R4 7Dh to 83h");
    // R5: increment and decrement incl. wrap
    for (int a = 0; a < 256; a++) begin
      run(4, a, 0, a ^ 8'hff, a & 1, (a >> 1) & 1, (a >> 2) & 1, "R5 inc");
      run(5, a, 0, a, (a >> 3) & 1, a & 1, 1, "R5 dec");
    end
    // R6 and R10: multiply sweep
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 5)
        run(6, a, 0, b, 1, a & 1, 0, "R6/R10 mul");
    run(6, 8'h25, 0, 8'h65, 1, 0, 0, "R6 25h x 65h");
    run(6, 8'hff, 0, 8'hff, 0, 1, 0, "R6 max product");
    // R7, R8 and R10: divide sweep incl. zero divisor
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 5)
        run(7, a, 0, b, 1, a & 1, 1, "R7/R8/R10 div");
    run(7, 95, 0, 10, 1, 0, 1, "R7 95/10");
    run(7, 8'hff, 0, 1, 0, 0, 0, "R7 divide by one");
    for (int a = 0; a < 256; a += 17)
      run(7, a, 0, 0, 1, 1, 0, "R8 divide by zero");
    // R9: back-to-back single-cycle ops
    run(0, 8'h99, 8'h01, 0, 0, 0, 0, "R9 single cycle");
    run(3, 8'h9a, 0, 0, 0, 0, 0, "R9 single cycle da");
    summary();
  end
endmodule